// File: doc/BRIEF.md
# Stream FIFO with Null-Beat Removal

This block is a single-clock FIFO for byte-qualified streaming traffic. Each beat carries a data word, a per-byte keep mask and an end-of-packet marker. All three are stored together and leave the FIFO in the order they were accepted. Both sides use a valid/ready handshake. The occupancy drives four registered level flags: full, almost-full, almost-empty and empty. The almost-full and almost-empty thresholds are parameters.

A build-time option filters beats on the write side. When it is enabled, a beat whose keep mask has no bit set still completes its input handshake. It is then discarded before it reaches storage, so it takes no entry and never appears at the output. This lets a consumer see an unbroken run of useful beats when width-converting stages upstream emit empty ones. When the option is disabled, every accepted beat is stored, including empty ones.

Top module: `strm_fifo`

## Requirements
- R1: Stored beats leave the FIFO in acceptance order, with `m_data` equal to the accepted `s_data`. `m_valid` is high exactly when at least one entry is stored.
- R2: `m_keep` and `m_last` leave with the same values that `s_keep` and `s_last` had when that beat was accepted.
- R3: With `DROP_NULL`=1, an accepted beat with `s_keep` equal to zero is never stored and never appears at the output.
- R4: With `DROP_NULL`=1, a dropped beat still completes its handshake (`s_ready` is not lowered because of it) and leaves the occupancy unchanged. A null beat sent into an empty FIFO leaves `m_valid` low.
- R5: With `DROP_NULL`=0, a beat with `s_keep` equal to zero is stored and forwarded like any other beat.
- R6: `full` is high exactly when `DEPTH` entries are stored. It is set directly after the clock edge whose write fills the last entry. `s_ready` equals the inverse of `full`, and no beat is accepted while `full` is high.
- R7: `almost_full` is high exactly when the occupancy is at or above `AF_LEVEL`.
- R8: `almost_empty` is high exactly when the occupancy is at or below `AE_LEVEL`.
- R9: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data`, `m_keep` and `m_last` do not change on the next cycle.
- R10: After reset the FIFO is empty: `m_valid` is 0, `s_ready` is 1, `full` is 0, `almost_full` is 0 and `almost_empty` is 1 (defaults `AF_LEVEL`=6, `AE_LEVEL`=2).
- R11: With `DROP_NULL`=1, when a dropped null beat carries `s_last`=1, that marker is lost. The next stored beat keeps its own `s_last` value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Input beat present |
| s_ready | output | 1 | FIFO can accept a beat |
| s_data | input | DATA_W | Input data word |
| s_keep | input | DATA_W/8 | Input byte-keep mask |
| s_last | input | 1 | Input end-of-packet marker |
| m_valid | output | 1 | Output beat present |
| m_ready | input | 1 | Consumer takes the output beat |
| m_data | output | DATA_W | Output data word |
| m_keep | output | DATA_W/8 | Output byte-keep mask |
| m_last | output | 1 | Output end-of-packet marker |
| full | output | 1 | All DEPTH entries are occupied |
| almost_full | output | 1 | Occupancy is at or above AF_LEVEL |
| almost_empty | output | 1 | Occupancy is at or below AE_LEVEL |

## Verification
The hardest case to reach from the ports is a null beat that arrives while the FIFO is nearly full or already holds partial packets. There, the drop must leave `s_ready`, the flags and the next beat's end marker untouched. The bench drives two instances that differ only in the filter option with one shared stimulus. The mix includes frequent all-zero keep masks, some with the end marker set, and consumer-ready phases biased toward filling and toward draining. This sweeps every occupancy level while null beats arrive at each of them. A short directed sequence also sends null beats into an empty FIFO and counts the beats that each instance releases.

// File: rtl/strm_fifo_pkg.sv
package strm_fifo_pkg;

    // Registered occupancy indicators shared by the controller and the top.
    typedef struct packed {
        logic full;
        logic almost_full;
        logic almost_empty;
        logic empty;
    } lvl_flags_t;

endpackage

// File: rtl/strm_fifo_filter.sv
module strm_fifo_filter #(
    parameter int KEEP_W    = 4,
    parameter bit DROP_NULL = 1'b1
) (
    input  logic              in_fire,
    input  logic [KEEP_W-1:0] in_keep,
    output logic              store_en
);

    generate
        if (DROP_NULL) begin : g_drop
            // A completed handshake is stored only if some byte is kept.
            assign store_en = in_fire && (|in_keep);
        end else begin : g_pass
            assign store_en = in_fire;
        end
    endgenerate

endmodule

// File: rtl/strm_fifo_mem.sv
module strm_fifo_mem #(
    parameter int WIDTH = 37,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // The head entry is presented combinationally from the read pointer.
    assign rdata = cells[raddr];

endmodule

// File: rtl/strm_fifo_ctrl.sv
module strm_fifo_ctrl
    import strm_fifo_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int AF_LEVEL = 6,
    parameter int AE_LEVEL = 2,
    localparam int AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output lvl_flags_t    flags
);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
        lvl_flags_t    fl;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    function automatic lvl_flags_t lvl_of(input logic [CW-1:0] c);
        lvl_flags_t f;
        f.full         = (c == CW'(DEPTH));
        f.almost_full  = (c >= CW'(AF_LEVEL));
        f.almost_empty = (c <= CW'(AE_LEVEL));
        f.empty        = (c == '0);
        return f;
    endfunction

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.wr = ptr_inc(st_q.wr);
        end
        if (pop) begin
            st_d.rd = ptr_inc(st_q.rd);
        end
        st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
        // Flags follow the next occupancy so they line up with the write.
        st_d.fl  = lvl_of(st_d.cnt);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.wr  <= '0;
            st_q.rd  <= '0;
            st_q.cnt <= '0;
            st_q.fl  <= lvl_of('0);
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ptr = st_q.wr;
    assign rd_ptr = st_q.rd;
    assign flags  = st_q.fl;

    assert_no_overflow_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fl.full |-> !push);

    assert_no_underflow_R1 : assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fl.empty |-> !pop);

    assert_full_clears_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> !st_q.fl.full);

    assert_fill_leaves_empty_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> !st_q.fl.empty);

    assert_af_on_rise_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.fl.almost_full) |-> $past(push));

endmodule

// File: rtl/strm_fifo.sv
module strm_fifo
    import strm_fifo_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int DEPTH    = 8,
    parameter int AF_LEVEL = 6,
    parameter int AE_LEVEL = 2,
    parameter bit DROP_NULL = 1'b1,
    localparam int KEEP_W  = DATA_W / 8,
    localparam int BEAT_W  = DATA_W + KEEP_W + 1,
    localparam int AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    input  logic [KEEP_W-1:0] s_keep,
    input  logic              s_last,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [DATA_W-1:0] m_data,
    output logic [KEEP_W-1:0] m_keep,
    output logic              m_last,
    output logic              full,
    output logic              almost_full,
    output logic              almost_empty
);

    lvl_flags_t        flags;
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic              s_fire, store_en, pop;
    logic [BEAT_W-1:0] head_beat;

    assign s_ready = !flags.full;
    assign m_valid = !flags.empty;
    assign s_fire  = s_valid && s_ready;
    assign pop     = m_valid && m_ready;

    strm_fifo_filter #(
        .KEEP_W   (KEEP_W),
        .DROP_NULL(DROP_NULL)
    ) u_filter (
        .in_fire (s_fire),
        .in_keep (s_keep),
        .store_en(store_en)
    );

    strm_fifo_ctrl #(
        .DEPTH   (DEPTH),
        .AF_LEVEL(AF_LEVEL),
        .AE_LEVEL(AE_LEVEL)
    ) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (store_en),
        .pop   (pop),
        .wr_ptr(wr_ptr),
        .rd_ptr(rd_ptr),
        .flags (flags)
    );

    strm_fifo_mem #(
        .WIDTH(BEAT_W),
        .DEPTH(DEPTH)
    ) u_mem (
        .clk  (clk),
        .we   (store_en),
        .waddr(wr_ptr),
        .wdata({s_last, s_keep, s_data}),
        .raddr(rd_ptr),
        .rdata(head_beat)
    );

    assign {m_last, m_keep, m_data} = head_beat;
    assign full         = flags.full;
    assign almost_full  = flags.almost_full;
    assign almost_empty = flags.almost_empty;

    assert_hold_stall_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(head_beat)));

    generate
        if (DROP_NULL) begin : g_chk_drop
            assert_null_not_stored_R3 : assert property (@(posedge clk) disable iff (!rst_n)
                (s_fire && (s_keep == '0)) |-> !store_en);
        end else begin : g_chk_pass
            assert_null_stored_R5 : assert property (@(posedge clk) disable iff (!rst_n)
                s_fire |-> store_en);
        end
    endgenerate

endmodule

// File: tb/strm_fifo_test.sv
module strm_fifo_test;

    localparam int DW  = 16;
    localparam int KW  = DW / 8;
    localparam int DP  = 8;
    localparam int AFL = 6;
    localparam int AEL = 2;
    localparam int BW  = DW + KW + 1;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          s_valid = 1'b0;
    logic [DW-1:0] s_data = '0;
    logic [KW-1:0] s_keep = '0;
    logic          s_last = 1'b0;
    logic          m_ready = 1'b0;

    logic [1:0]         sr, mv, ml, fu, af, ae;
    logic [1:0][DW-1:0] md;
    logic [1:0][KW-1:0] mk;

    strm_fifo #(.DATA_W(DW), .DEPTH(DP), .AF_LEVEL(AFL), .AE_LEVEL(AEL), .DROP_NULL(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(sr[0]), .s_data(s_data),
        .s_keep(s_keep), .s_last(s_last), .m_valid(mv[0]), .m_ready(m_ready),
        .m_data(md[0]), .m_keep(mk[0]), .m_last(ml[0]), .full(fu[0]),
        .almost_full(af[0]), .almost_empty(ae[0]));

    strm_fifo #(.DATA_W(DW), .DEPTH(DP), .AF_LEVEL(AFL), .AE_LEVEL(AEL), .DROP_NULL(1'b0)) uut_keep_all (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(sr[1]), .s_data(s_data),
        .s_keep(s_keep), .s_last(s_last), .m_valid(mv[1]), .m_ready(m_ready),
        .m_data(md[1]), .m_keep(mk[1]), .m_last(ml[1]), .full(fu[1]),
        .almost_full(af[1]), .almost_empty(ae[1]));

    int checks = 0;
    int errors = 0;

    logic [BW-1:0] mq [2][16];
    int hd [2];
    int n  [2];
    int popcnt [2];
    logic [31:0] rng = 32'h1234_5678;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(input logic [1:0] stall, input logic [1:0][BW-1:0] held);
        for (int i = 0; i < 2; i++) begin
            chk("R1 m_valid", 32'(mv[i]), 32'(n[i] > 0));
            if (n[i] > 0) begin
                chk("R1 m_data", 32'(md[i]), 32'(mq[i][hd[i]][DW-1:0]));
                chk("R2 keep/last", 32'({ml[i], mk[i]}), 32'(mq[i][hd[i]][BW-1:DW]));
            end
            chk("R6 full", 32'(fu[i]), 32'(n[i] == DP));
            chk("R6 s_ready", 32'(sr[i]), 32'(n[i] != DP));
            chk("R7 almost_full", 32'(af[i]), 32'(n[i] >= AFL));
            chk("R8 almost_empty", 32'(ae[i]), 32'(n[i] <= AEL));
            if (stall[i]) begin
                chk("R9 held valid", 32'(mv[i]), 32'd1);
                chk("R9 held beat", 32'({ml[i], mk[i], md[i]}), 32'(held[i]));
            end
        end
    endtask

    // Drives one cycle at a falling edge, then updates the models and checks.
    task automatic step(input logic sv, input logic [DW-1:0] sd, input logic [KW-1:0] sk,
                        input logic sl, input logic mr);
        logic [1:0] acc, pp, stall;
        logic [1:0][BW-1:0] held;
        s_valid = sv; s_data = sd; s_keep = sk; s_last = sl; m_ready = mr;
        #1;
        for (int i = 0; i < 2; i++) begin
            acc[i]   = sv && sr[i];
            pp[i]    = mv[i] && mr;
            stall[i] = mv[i] && !mr;
            held[i]  = {ml[i], mk[i], md[i]};
        end
        @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            if (pp[i]) begin
                hd[i] = (hd[i] + 1) % 16;
                n[i]--;
                popcnt[i]++;
            end
            // R3/R11: the filtering instance never stores an all-zero keep beat.
            if (acc[i] && !(i == 0 && sk == '0)) begin
                mq[i][(hd[i] + n[i]) % 16] = {sl, sk, sd};
                n[i]++;
            end
        end
        check_all(stall, held);
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            hd[i] = 0; n[i] = 0; popcnt[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        for (int i = 0; i < 2; i++) begin
            chk("R10 m_valid", 32'(mv[i]), 32'd0);
            chk("R10 s_ready", 32'(sr[i]), 32'd1);
            chk("R10 full", 32'(fu[i]), 32'd0);
            chk("R10 almost_full", 32'(af[i]), 32'd0);
            chk("R10 almost_empty", 32'(ae[i]), 32'd1);
        end

        // Fill sweep through every occupancy, including writes refused at full (R6, R7, R8).
        for (int k = 0; k < 11; k++) begin
            step(1'b1, DW'(16'hA000 + k), KW'(k % 3 + 1), (k % 3) == 0, 1'b0);
        end
        for (int k = 0; k < 10; k++) step(1'b0, '0, '0, 1'b0, 1'b1);

        // R4/R5: a null beat into an empty FIFO.
        step(1'b1, DW'(16'h5555), '0, 1'b0, 1'b0);
        chk("R4 null into empty leaves m_valid low", 32'(mv[0]), 32'd0);
        chk("R4 s_ready after drop", 32'(sr[0]), 32'd1);
        chk("R5 null stored when filter off", 32'(mv[1]), 32'd1);
        for (int k = 0; k < 3; k++) step(1'b0, '0, '0, 1'b0, 1'b1);

        // R3/R11: null beats carrying an end marker between real beats.
        popcnt[0] = 0; popcnt[1] = 0;
        step(1'b1, DW'(16'h0101), 2'b01, 1'b0, 1'b0);
        step(1'b1, DW'(16'h0202), 2'b00, 1'b1, 1'b0);
        step(1'b1, DW'(16'h0303), 2'b10, 1'b0, 1'b0);
        chk("R11 next beat keeps its own last", 32'(n[0] == 2 && mq[0][(hd[0] + 1) % 16][BW-1] == 1'b0), 32'd1);
        step(1'b1, DW'(16'h0404), 2'b00, 1'b0, 1'b0);
        for (int k = 0; k < 6; k++) step(1'b0, '0, '0, 1'b0, 1'b1);
        chk("R3 beats released with filter", 32'(popcnt[0]), 32'd2);
        chk("R5 beats released without filter", 32'(popcnt[1]), 32'd4);

        // Mixed traffic with fill- and drain-biased phases.
        for (int c = 0; c < 3000; c++) begin
            logic sv, mr, sl;
            logic [KW-1:0] sk;
            rng = nxt(rng);
            sv = rng[1:0] != 2'b00;
            sk = (rng[3:2] == 2'b00) ? '0 : rng[5:4];
            sl = rng[6];
            if (((c / 150) % 2) == 0) mr = rng[9:8] == 2'b00;
            else                      mr = rng[9:8] != 2'b00;
            step(sv, rng[31:16], sk, sl, mr);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule